// File: doc/BRIEF.md
# Parallel-Lookup Physically Tagged Read Cache

This block is a read cache meant to sit beside an address translation buffer. The set index and the byte select are taken only from the page-offset bits of the virtual address. The set can therefore be read in the same cycle that translation produces the physical frame number. That frame number is then compared against the tags stored in each way. Because the page offset is 12 bits wide, the index cannot grow past 10 bits. The 8 KB capacity is reached with two ways per set, not with a wider index.

The requester presents a virtual address, the translated frame and a flag that says whether translation succeeded. A hit returns the word in the same cycle. A miss starts a one-word refill from memory at the physical address, and the block stops accepting requests until the refill completes. The word that memory returns is written into the chosen way and passed to the requester in the cycle of the response. Within a set, the block replaces an empty way first. When both ways are full it replaces the way used least recently, which it tracks with one bit per set.

Top module: `vipt_cache`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, and `mem_req` and `rd_valid` are 0. The first access to any set is a miss.
- R2: The set is `req_vaddr[11:2]`, which is the block address modulo 1024. A lookup hits when a valid way in that set holds a tag equal to `tlb_pfn`. On a hit, `hit` and `rd_valid` are 1 and `rd_data` carries the stored word, all in the request cycle.
- R3: On a miss, `miss` is 1 in the request cycle. From the next cycle `mem_req` is 1 and `mem_addr` equals `{tlb_pfn, req_vaddr[11:2], 2'b00}` as captured at the miss, and both hold until the response arrives.
- R4: In the cycle `mem_resp_valid` is 1 during a refill, `rd_valid` is 1 and `rd_data` equals `mem_resp_data`. A later lookup of the same frame and offset hits with that word.
- R5: When `tlb_ok` is 0, a request produces neither `hit` nor `miss`, and no refill starts.
- R6: A refill goes to an invalid way if the set has one, with way 0 taken before way 1.
- R7: Each set keeps one bit naming its least recently used way. Every hit and every refill updates it. When both ways are valid, a refill replaces that way.
- R8: Two different frames that share a page offset can be resident together, one in each way of the set.
- R9: The virtual page number does not take part in the lookup. Two virtual addresses with the same offset that translate to the same frame hit the same entry.
- R10: While a refill is outstanding, `req_ready` is 0, and requests produce neither `hit` nor `miss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address of the request |
| tlb_ok | input | 1 | Translation succeeded this cycle |
| tlb_pfn | input | 20 | Physical frame number from translation |
| req_ready | output | 1 | Block can accept a lookup |
| hit | output | 1 | Lookup found the word |
| miss | output | 1 | Lookup missed, refill starts |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| rd_data | output | 32 | Word returned to the requester |
| mem_req | output | 1 | Refill read request, held until response |
| mem_addr | output | 32 | Physical word address of the refill |
| mem_resp_valid | input | 1 | Memory returns the refill word |
| mem_resp_data | input | 32 | Refill word |

## Verification
The assertions assume that `tlb_pfn` and `tlb_ok` arrive in the same cycle as the request. They also assume that memory raises `mem_resp_valid` only while `mem_req` is high, and that it raises it exactly once per request. The bench's memory model counts a fixed latency from the rise of `mem_req` and answers once. The driver waits for `req_ready` after every miss. The only requests made while a refill is outstanding are the deliberate ones in the R10 test.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_OFF_W = 12;
    localparam int BSEL_W     = 2;
    localparam int DATA_W     = 32;
    localparam int WAYS       = 2;
    localparam int PFN_W      = ADDR_W - PAGE_OFF_W;
    localparam int IDX_W      = PAGE_OFF_W - BSEL_W;
    localparam int SETS       = 1 << IDX_W;

    typedef logic [PFN_W-1:0]  pfn_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic valid;
        pfn_t tag;
    } tag_ent_t;

    typedef enum logic {ST_LOOKUP, ST_REFILL} ctl_st_e;

    // set selection: block address modulo number of sets, untranslated bits only
    function automatic idx_t set_of(addr_t va);
        return va[PAGE_OFF_W-1:BSEL_W];
    endfunction

    function automatic addr_t word_paddr(pfn_t pfn, idx_t idx);
        return {pfn, idx, {BSEL_W{1'b0}}};
    endfunction

    // empty way first (lowest), otherwise least recently used
    function automatic logic pick_victim(logic [WAYS-1:0] vld, logic lru);
        if (!vld[0]) return 1'b0;
        if (!vld[1]) return 1'b1;
        return lru;
    endfunction
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
    import vipt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  idx_t                  rd_idx,
    output tag_ent_t [WAYS-1:0]   rd_ents,
    output logic                  rd_lru,
    input  logic                  wr_en,
    input  idx_t                  wr_idx,
    input  logic                  wr_way,
    input  pfn_t                  wr_tag,
    input  logic                  touch_en,
    input  idx_t                  touch_idx,
    input  logic                  touch_way
);
    logic [WAYS-1:0] valid_q [SETS];
    pfn_t            tag_q   [SETS][WAYS];
    logic            lru_q   [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                lru_q[s]   <= 1'b0;
            end
        end else begin
            if (wr_en) valid_q[wr_idx][wr_way] <= 1'b1;
            if (touch_en) lru_q[touch_idx] <= ~touch_way;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx][wr_way] <= wr_tag;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_ents[w].valid = valid_q[rd_idx][w];
        assign rd_ents[w].tag   = tag_q[rd_idx][w];
    end
    assign rd_lru = lru_q[rd_idx];
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
    import vipt_pkg::*;
(
    input  logic               clk,
    input  idx_t               rd_idx,
    output word_t [WAYS-1:0]   rd_words,
    input  logic               wr_en,
    input  idx_t               wr_idx,
    input  logic               wr_way,
    input  word_t              wr_data
);
    word_t mem_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx][wr_way] <= wr_data;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_words[w] = mem_q[rd_idx][w];
    end
endmodule

// File: rtl/vipt_refill_ctrl.sv
module vipt_refill_ctrl
    import vipt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  pfn_t    start_pfn,
    input  idx_t    start_idx,
    input  logic    resp_valid,
    output logic    ready,
    output logic    mem_req,
    output addr_t   mem_addr,
    output logic    fill_fire,
    output idx_t    fill_idx,
    output pfn_t    fill_pfn
);
    ctl_st_e st_q;
    pfn_t    pfn_q;
    idx_t    idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_LOOKUP;
            pfn_q <= '0;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                ST_LOOKUP: if (start) begin
                    st_q  <= ST_REFILL;
                    pfn_q <= start_pfn;
                    idx_q <= start_idx;
                end
                ST_REFILL: if (resp_valid) st_q <= ST_LOOKUP;
                default: st_q <= ST_LOOKUP;
            endcase
        end
    end

    assign ready     = (st_q == ST_LOOKUP);
    assign mem_req   = (st_q == ST_REFILL);
    assign mem_addr  = word_paddr(pfn_q, idx_q);
    assign fill_fire = mem_req && resp_valid;
    assign fill_idx  = idx_q;
    assign fill_pfn  = pfn_q;
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_vaddr,
    input  logic                tlb_ok,
    input  logic [PFN_W-1:0]    tlb_pfn,
    output logic                req_ready,
    output logic                hit,
    output logic                miss,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_resp_valid,
    input  logic [DATA_W-1:0]   mem_resp_data
);
    idx_t              req_idx, look_idx, fill_idx;
    pfn_t              fill_pfn;
    tag_ent_t [WAYS-1:0] ents;
    word_t    [WAYS-1:0] words;
    logic [WAYS-1:0]   way_hit, ents_vld;
    logic              lru, hit_way, victim, lookup, fill_fire;
    logic              unused_vpn_bsel;

    assign req_idx  = set_of(req_vaddr);
    // the page number and byte select play no part in the lookup
    assign unused_vpn_bsel = ^{req_vaddr[ADDR_W-1:PAGE_OFF_W], req_vaddr[BSEL_W-1:0]};
    assign look_idx = req_ready ? req_idx : fill_idx;

    vipt_tag_store u_tags (
        .clk(clk), .rst(rst),
        .rd_idx(look_idx), .rd_ents(ents), .rd_lru(lru),
        .wr_en(fill_fire), .wr_idx(fill_idx), .wr_way(victim), .wr_tag(fill_pfn),
        .touch_en(hit || fill_fire),
        .touch_idx(fill_fire ? fill_idx : req_idx),
        .touch_way(fill_fire ? victim : hit_way)
    );

    vipt_data_store u_data (
        .clk(clk),
        .rd_idx(look_idx), .rd_words(words),
        .wr_en(fill_fire), .wr_idx(fill_idx), .wr_way(victim), .wr_data(mem_resp_data)
    );

    vipt_refill_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .start(miss), .start_pfn(tlb_pfn), .start_idx(req_idx),
        .resp_valid(mem_resp_valid),
        .ready(req_ready), .mem_req(mem_req), .mem_addr(mem_addr),
        .fill_fire(fill_fire), .fill_idx(fill_idx), .fill_pfn(fill_pfn)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w]  = ents[w].valid && (ents[w].tag == tlb_pfn);
        assign ents_vld[w] = ents[w].valid;
    end

    assign hit_way  = way_hit[1];
    assign victim   = pick_victim(ents_vld, lru);
    assign lookup   = req_valid && req_ready && tlb_ok;
    assign hit      = lookup && (|way_hit);
    assign miss     = lookup && !(|way_hit);
    assign rd_valid = hit || fill_fire;
    assign rd_data  = fill_fire ? mem_resp_data : words[hit_way];
endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk
    import vipt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              tlb_ok,
    input logic [PFN_W-1:0]  tlb_pfn,
    input logic              req_ready,
    input logic              hit,
    input logic              miss,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_resp_valid,
    input logic [DATA_W-1:0] mem_resp_data
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (req_ready && !mem_req && !rd_valid));

    assert_hit_is_read_R2: assert property (@(posedge clk) disable iff (rst)
        hit |-> (rd_valid && req_valid && tlb_ok && !miss));

    assert_refill_addr_R3: assert property (@(posedge clk) disable iff (rst)
        miss |=> (mem_req && mem_addr == {$past(tlb_pfn), $past(req_vaddr[PAGE_OFF_W-1:BSEL_W]), {BSEL_W{1'b0}}}));

    assert_refill_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_resp_valid) |=> (mem_req && $stable(mem_addr)));

    assert_fill_forward_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_resp_valid) |-> (rd_valid && rd_data == mem_resp_data));

    assert_no_xlate_no_lookup_R5: assert property (@(posedge clk) disable iff (rst)
        !tlb_ok |-> (!hit && !miss));

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (!hit && !miss));
endmodule

bind vipt_cache vipt_cache_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tlb_ok(tlb_ok), .tlb_pfn(tlb_pfn), .req_ready(req_ready), .hit(hit),
    .miss(miss), .rd_valid(rd_valid), .rd_data(rd_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
);

// File: tb/vipt_cache_tb.sv
`timescale 1ns/1ps
module vipt_cache_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        tlb_ok = 1'b0;
    logic [19:0] tlb_pfn = '0;
    logic        req_ready, hit, miss, rd_valid, mem_req;
    logic [31:0] rd_data, mem_addr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    logic [31:0] exp_paddr = '0;

    always #2 clk = ~clk;

    vipt_cache u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .tlb_ok(tlb_ok), .tlb_pfn(tlb_pfn), .req_ready(req_ready), .hit(hit),
        .miss(miss), .rd_valid(rd_valid), .rd_data(rd_data), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
    );

    function automatic logic [31:0] mem_word(logic [31:0] pa);
        return (pa * 32'h9E37_79B9) ^ 32'h5A5A_5A5A;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model: answers after three cycles of mem_req, checks the address (R3)
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            mem_resp_valid = 1'b0;
            if (mem_req) begin
                cnt++;
                if (cnt == 3) begin
                    check(mem_addr == exp_paddr, "R3 refill address", mem_addr, exp_paddr);
                    mem_resp_valid = 1'b1;
                    mem_resp_data  = mem_word(mem_addr);
                    cnt = 0;
                end
            end else cnt = 0;
        end
    end

    // scoreboard monitor (R2 hit data, R4 forwarded refill data)
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_valid) begin
                if (exp_q.size() == 0) check(1'b0, "R2/R4 unexpected rd_valid", rd_data, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R2/R4 read data", rd_data, e);
                end
            end
        end
    end

    task automatic access(input logic [31:0] va, input logic [19:0] pfn, input bit ok,
                          input bit exp_hit, input string req, input bit wait_done = 1'b1);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; tlb_pfn = pfn; tlb_ok = ok;
        exp_paddr = {pfn, va[11:2], 2'b00};
        if (ok) exp_q.push_back(mem_word(exp_paddr));
        #1;
        check(hit == (ok && exp_hit), {req, " hit"}, {31'b0, hit}, {31'b0, ok && exp_hit});
        check(miss == (ok && !exp_hit), {req, " miss"}, {31'b0, miss}, {31'b0, ok && !exp_hit});
        @(negedge clk);
        req_valid = 1'b0; tlb_ok = 1'b0;
        if (wait_done) while (!req_ready) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check(req_ready == 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'd1);
        check(mem_req == 1'b0, "R1 no request after reset", {31'b0, mem_req}, 32'd0);
        check(rd_valid == 1'b0, "R1 no read after reset", {31'b0, rd_valid}, 32'd0);

        // R1 cold miss, R3 refill, R4 install then hit
        access(32'h0000_1234, 20'h00ABC, 1, 0, "R1 cold");
        access(32'h0000_1234, 20'h00ABC, 1, 1, "R4 refilled hit");
        // R9 different virtual page, same frame
        access(32'h7777_7234, 20'h00ABC, 1, 1, "R9 vpn ignored");
        // R5 translation failure
        access(32'h0000_1234, 20'h00ABC, 0, 0, "R5 no xlate");
        #1;
        check(mem_req == 1'b0, "R5 no refill", {31'b0, mem_req}, 32'd0);
        // R6/R8 second frame fills the empty way, both resident
        access(32'h0000_5234, 20'h00DEF, 1, 0, "R6 second frame miss");
        access(32'h0000_5234, 20'h00DEF, 1, 1, "R8 way1 hit");
        access(32'h0000_1234, 20'h00ABC, 1, 1, "R8 way0 still hit");
        // R7 LRU: ABC used last, so 12345 evicts DEF
        access(32'h0000_9234, 20'h12345, 1, 0, "R7 third frame miss");
        access(32'h0000_1234, 20'h00ABC, 1, 1, "R7 recent survives");
        access(32'h0000_9234, 20'h12345, 1, 1, "R7 new resident");
        access(32'h0000_5234, 20'h00DEF, 1, 0, "R7 lru evicted");
        // R2 index extremes
        access(32'h0000_0000, 20'h00001, 1, 0, "R2 set0 miss");
        access(32'h0000_0FFC, 20'h00001, 1, 0, "R2 set1023 miss");
        access(32'h0000_0003, 20'h00001, 1, 1, "R2 set0 hit byte sel");
        access(32'h0000_0FFC, 20'h00001, 1, 1, "R2 set1023 hit");
        access(32'h0000_0000, 20'h00002, 1, 0, "R2 tag mismatch");

        // R10 requests during refill are ignored
        access(32'h0000_0400, 20'h00033, 1, 0, "R10 start refill", 1'b0);
        req_valid = 1'b1; req_vaddr = 32'h0000_0FFC; tlb_pfn = 20'h00001; tlb_ok = 1'b1;
        #1;
        check(req_ready == 1'b0, "R10 busy", {31'b0, req_ready}, 32'd0);
        check(hit == 1'b0 && miss == 1'b0, "R10 ignored", {30'b0, hit, miss}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0; tlb_ok = 1'b0;
        while (!req_ready) @(negedge clk);
        access(32'h0000_0400, 20'h00033, 1, 1, "R10 refill done hit");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule